// File: doc/BRIEF.md
# Card Window Address Decoder

This block sits between a host bus and a card socket controller. It matches each host access against a bank of programmable windows. Every window has a base word and an option word. For the access it finds the winning window and then hands the socket logic what it needs: the card-side address, the address space, the slot, the port width and a strobe sequence. The strobe sequence is paced by the setup, length and hold counts stored in that window's option word.

Software programs the windows through a small register port. The port addresses a window by index and selects either its base word or its option word. A window's size is a power of two. The option word stores the exponent as a reflected Gray code. There is no address offset: the card address is simply the low bits of the host address. An access that matches no window is reported as a miss. A write to a protected window is refused and reported. Neither case drives a strobe.

Top module: `card_window_decoder`

## Requirements
- R1: Each of the 8 windows holds a 32-bit base word and a 32-bit option word. A register write with `regIsOpt`=0 sets the base word of window `regSel`, and with `regIsOpt`=1 it sets the option word. `regRdData` returns the selected word at once. After reset every word reads 0.
- R2: A window whose option bit 0 (valid) is 0 never hits, whatever its other fields hold.
- R3: Option bits 31:27 hold the reflected Gray code of n, where the window size is 2^n bytes and n runs from 0 to 26. A window hits only for addresses that are at or above the base and below the base plus 2^n.
- R4: If a size field decodes to an n above 26, the window never hits.
- R5: A hit also requires `accSpace` to equal option bits 5:3. The space codes are 0 common memory, 2 attribute memory, 3 I/O, 4 DMA, 5 DMA last transfer and 6 upper-address-on-enables.
- R6: When several windows hit, the lowest-numbered window wins, and its index appears on `hitIdx`.
- R7: An accepted hit latches the following, which stay valid until the next accepted hit: `cardAddr` as the low 26 bits of `accAddr`; `cardSpace` from option bits 5:3; `slotB` from option bit 2; `port16` from option bit 6; and `cardWrite`.
- R8: Call the cycle after the accepting edge cycle 1. After a hit, `strobe` stays low for S cycles, where S is option bits 15:12. It is then high for L cycles, where L is bits 11:7. It is then low for H hold cycles, where H is bits 19:16. `done` is high alone in cycle S+L+H+1. `busy` is high from cycle 1 through cycle S+L+H+1.
- R9: `accValid` is ignored while `busy` is high. The context latched under R7 does not change during that time.
- R10: A write that hits a window with option bit 1 (write protect) set raises `protErr` for cycle 1 only. It drives no strobe and no done, and it does not make the block busy. Reads of the same window proceed normally.
- R11: An access that hits no window raises `noHit` for cycle 1 only. It drives no strobe and no done, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write enable |
| regSel | input | 3 | Window index for register access |
| regIsOpt | input | 1 | 1 selects the option word, 0 the base word |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Selected register word |
| accValid | input | 1 | Host access request, sampled when idle |
| accAddr | input | 32 | Host address |
| accWrite | input | 1 | Access is a write |
| accSpace | input | 3 | Requested address space code |
| busy | output | 1 | Strobe sequence in progress |
| noHit | output | 1 | One-cycle miss flag |
| protErr | output | 1 | One-cycle write-protect violation flag |
| hitIdx | output | 3 | Index of the winning window |
| cardAddr | output | 26 | Card-side address |
| cardSpace | output | 3 | Space code of the winning window |
| cardWrite | output | 1 | Latched direction of the access |
| slotB | output | 1 | Slot B selected |
| port16 | output | 1 | 16-bit port selected |
| strobe | output | 1 | Card access strobe |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench builds the block with its default 8 windows, a 32-bit address and a 26-bit card address. With these values it can reach every size exponent from 0 to 26, and it probes the four edge addresses around each one. It also tries the five Gray codes that lie beyond the valid range. A full sweep of space codes is run against one window type. Overlapping windows test the priority order. Several strobe profiles are run, including all-zero counts and the largest counts, so every phase skip is seen. One long profile carries an extra request mid-flight to show that requests are ignored while busy.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  localparam int OPT_VALID  = 0;
  localparam int OPT_WPROT  = 1;
  localparam int OPT_SLOTB  = 2;
  localparam int OPT_TYPE_LO = 3;
  localparam int OPT_PORT16 = 6;
  localparam int OPT_LEN_LO = 7;
  localparam int OPT_SETUP_LO = 12;
  localparam int OPT_HOLD_LO = 16;
  localparam int OPT_SIZE_LO = 27;

  localparam int SETUP_W = 4;
  localparam int LEN_W   = 5;
  localparam int HOLD_W  = 4;
  localparam int CNT_W   = 5;
  localparam int SIZE_W  = 5;
  localparam int SPACE_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_DONE
  } phase_t;

  typedef struct packed {
    logic capture;
  } ctl_t;

  typedef struct packed {
    logic              anyHit;
    logic              blocked;
    logic [SETUP_W-1:0] setup;
    logic [LEN_W-1:0]   len;
    logic [HOLD_W-1:0]  hold;
  } dec_t;

  typedef struct packed {
    phase_t           ph;
    logic [CNT_W-1:0] cnt;
  } step_t;

  function automatic logic [SIZE_W-1:0] gray2bin(input logic [SIZE_W-1:0] g);
    logic [SIZE_W-1:0] b;
    b[SIZE_W-1] = g[SIZE_W-1];
    for (int i = SIZE_W-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/cwd_datapath.sv
module cwd_datapath
  import cwd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  parameter int CARD_AW = 26,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [IDX_W-1:0]    regSel,
  input  logic                regIsOpt,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [DATA_W-1:0]   accAddr,
  input  logic                accWrite,
  input  logic [SPACE_W-1:0]  accSpace,
  input  ctl_t                ctl,
  output dec_t                dec,
  output logic [IDX_W-1:0]    hitIdx,
  output logic [CARD_AW-1:0]  cardAddr,
  output logic [SPACE_W-1:0]  cardSpace,
  output logic                cardWrite,
  output logic                slotB,
  output logic                port16
);

  localparam int MAX_LOG2 = CARD_AW;

  logic [DATA_W-1:0] baseReg [NUM_WIN];
  logic [DATA_W-1:0] optReg  [NUM_WIN];
  logic [NUM_WIN-1:0] hitVec;
  logic [IDX_W-1:0]   winIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < NUM_WIN; w++) begin
        baseReg[w] <= '0;
        optReg[w]  <= '0;
      end
    end else if (regWrEn) begin
      if (regIsOpt) optReg[regSel]  <= regWrData;
      else          baseReg[regSel] <= regWrData;
    end
  end

  assign regRdData = regIsOpt ? optReg[regSel] : baseReg[regSel];

  for (genvar w = 0; w < NUM_WIN; w++) begin : genWin
    logic [SIZE_W-1:0] sizeLog;
    logic [DATA_W:0]   winEnd;
    logic              inRange;
    assign sizeLog = gray2bin(optReg[w][OPT_SIZE_LO +: SIZE_W]);
    assign winEnd  = {1'b0, baseReg[w]} + ({{DATA_W{1'b0}}, 1'b1} << sizeLog);
    assign inRange = (accAddr >= baseReg[w]) && ({1'b0, accAddr} < winEnd);
    assign hitVec[w] = optReg[w][OPT_VALID]
                     && (int'(sizeLog) <= MAX_LOG2)
                     && inRange
                     && (optReg[w][OPT_TYPE_LO +: SPACE_W] == accSpace);
  end

  always_comb begin
    winIdx = '0;
    for (int w = NUM_WIN-1; w >= 0; w--) begin
      if (hitVec[w]) winIdx = IDX_W'(w);
    end
  end

  always_comb begin
    dec.anyHit  = |hitVec;
    dec.blocked = accWrite && optReg[winIdx][OPT_WPROT];
    dec.setup   = optReg[winIdx][OPT_SETUP_LO +: SETUP_W];
    dec.len     = optReg[winIdx][OPT_LEN_LO +: LEN_W];
    dec.hold    = optReg[winIdx][OPT_HOLD_LO +: HOLD_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitIdx    <= '0;
      cardAddr  <= '0;
      cardSpace <= '0;
      cardWrite <= 1'b0;
      slotB     <= 1'b0;
      port16    <= 1'b0;
    end else if (ctl.capture) begin
      hitIdx    <= winIdx;
      cardAddr  <= accAddr[CARD_AW-1:0];
      cardSpace <= optReg[winIdx][OPT_TYPE_LO +: SPACE_W];
      cardWrite <= accWrite;
      slotB     <= optReg[winIdx][OPT_SLOTB];
      port16    <= optReg[winIdx][OPT_PORT16];
    end
  end

endmodule

// File: rtl/cwd_control.sv
module cwd_control
  import cwd_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic accValid,
  input  dec_t dec,
  output ctl_t ctl,
  output logic busy,
  output logic strobe,
  output logic done,
  output logic noHit,
  output logic protErr
);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  lenQ;
  logic [HOLD_W-1:0] holdQ;
  step_t             nxt;
  logic              accept;

  function automatic step_t pickStep(input phase_t from,
                                     input logic [SETUP_W-1:0] s,
                                     input logic [LEN_W-1:0] l,
                                     input logic [HOLD_W-1:0] h);
    step_t r;
    r.ph  = PH_DONE;
    r.cnt = '0;
    if (from == PH_IDLE && s != '0) begin
      r.ph  = PH_SETUP;
      r.cnt = CNT_W'(s) - 1'b1;
    end else if ((from == PH_IDLE || from == PH_SETUP) && l != '0) begin
      r.ph  = PH_STROBE;
      r.cnt = CNT_W'(l) - 1'b1;
    end else if (from != PH_HOLD && h != '0) begin
      r.ph  = PH_HOLD;
      r.cnt = CNT_W'(h) - 1'b1;
    end
    return r;
  endfunction

  assign accept      = (phase == PH_IDLE) && accValid;
  assign ctl.capture = accept && dec.anyHit && !dec.blocked;

  always_comb begin
    if (phase == PH_IDLE) nxt = pickStep(PH_IDLE, dec.setup, dec.len, dec.hold);
    else                  nxt = pickStep(phase, '0, lenQ, holdQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      lenQ    <= '0;
      holdQ   <= '0;
      noHit   <= 1'b0;
      protErr <= 1'b0;
    end else begin
      noHit   <= 1'b0;
      protErr <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            if (!dec.anyHit) noHit <= 1'b1;
            else if (dec.blocked) protErr <= 1'b1;
            else begin
              lenQ  <= dec.len;
              holdQ <= dec.hold;
              phase <= nxt.ph;
              cnt   <= nxt.cnt;
            end
          end
        end
        PH_SETUP, PH_STROBE, PH_HOLD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            phase <= nxt.ph;
            cnt   <= nxt.cnt;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign strobe = (phase == PH_STROBE);
  assign done   = (phase == PH_DONE);

endmodule

// File: rtl/card_window_decoder.sv
module card_window_decoder
  import cwd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  parameter int CARD_AW = 26,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [IDX_W-1:0]   regSel,
  input  logic               regIsOpt,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               accValid,
  input  logic [DATA_W-1:0]  accAddr,
  input  logic               accWrite,
  input  logic [2:0]         accSpace,
  output logic               busy,
  output logic               noHit,
  output logic               protErr,
  output logic [IDX_W-1:0]   hitIdx,
  output logic [CARD_AW-1:0] cardAddr,
  output logic [2:0]         cardSpace,
  output logic               cardWrite,
  output logic               slotB,
  output logic               port16,
  output logic               strobe,
  output logic               done
);

  ctl_t ctl;
  dec_t dec;

  cwd_datapath #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .CARD_AW(CARD_AW)) dpath (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regIsOpt(regIsOpt),
    .regWrData(regWrData), .regRdData(regRdData),
    .accAddr(accAddr), .accWrite(accWrite), .accSpace(accSpace),
    .ctl(ctl), .dec(dec),
    .hitIdx(hitIdx), .cardAddr(cardAddr), .cardSpace(cardSpace),
    .cardWrite(cardWrite), .slotB(slotB), .port16(port16)
  );

  cwd_control ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .dec(dec), .ctl(ctl),
    .busy(busy), .strobe(strobe), .done(done), .noHit(noHit), .protErr(protErr)
  );

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int IDX_W   = 3,
  parameter int CARD_AW = 26
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               strobe,
  input logic               done,
  input logic               noHit,
  input logic               protErr,
  input logic [IDX_W-1:0]   hitIdx,
  input logic [CARD_AW-1:0] cardAddr
);

  // R11
  miss_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    noHit |-> (!busy && !strobe && !done));

  // R10
  prot_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    protErr |-> (!busy && !strobe && !done));

  // R8
  excl_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe, done, noHit, protErr}));

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R9
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> ($stable(hitIdx) && $stable(cardAddr)));

endmodule

bind card_window_decoder cwd_checker #(.IDX_W(IDX_W), .CARD_AW(CARD_AW)) chk (
  .clk(clk), .rstN(rstN), .busy(busy), .strobe(strobe), .done(done),
  .noHit(noHit), .protErr(protErr), .hitIdx(hitIdx), .cardAddr(cardAddr)
);

// File: tb/card_window_decoder_test.sv
module card_window_decoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic        regIsOpt = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic [2:0]  accSpace = '0;
  logic        busy, noHit, protErr, cardWrite, slotB, port16, strobe, done;
  logic [2:0]  hitIdx, cardSpace;
  logic [25:0] cardAddr;

  int checks = 0;
  int errors = 0;

  int rNoHit, rProt, rStrobes, rFirst, rDoneCnt, rDoneAt, rEnd;

  card_window_decoder uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regIsOpt(regIsOpt), .regWrData(regWrData), .regRdData(regRdData),
    .accValid(accValid), .accAddr(accAddr), .accWrite(accWrite),
    .accSpace(accSpace), .busy(busy), .noHit(noHit), .protErr(protErr),
    .hitIdx(hitIdx), .cardAddr(cardAddr), .cardSpace(cardSpace),
    .cardWrite(cardWrite), .slotB(slotB), .port16(port16),
    .strobe(strobe), .done(done)
  );

  always #10 clk = ~clk;

  task automatic chkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] optWord(input int lg, input int s, input int l,
      input int h, input bit p16, input int ty, input bit sb, input bit wp, input bit v);
    logic [31:0] w;
    int g;
    g = lg ^ (lg >> 1);
    w = '0;
    w[31:27] = g[4:0];
    w[19:16] = h[3:0];
    w[15:12] = s[3:0];
    w[11:7]  = l[4:0];
    w[6]     = p16;
    w[5:3]   = ty[2:0];
    w[2]     = sb;
    w[1]     = wp;
    w[0]     = v;
    return w;
  endfunction

  task automatic regWrite(input int w, input bit isOpt, input logic [31:0] d);
    @(negedge clk);
    regSel = w[2:0]; regIsOpt = isOpt; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input int w, input bit isOpt, output logic [31:0] d);
    @(negedge clk);
    regSel = w[2:0]; regIsOpt = isOpt;
    #2 d = regRdData;
  endtask

  task automatic clearOpts();
    for (int w = 0; w < 8; w++) regWrite(w, 1'b1, 32'h0);
  endtask

  task automatic runAcc(input logic [31:0] a, input bit wr, input int sp,
                        input int intrudeAt, input logic [31:0] intrudeAddr);
    @(negedge clk);
    accAddr = a; accWrite = wr; accSpace = sp[2:0]; accValid = 1'b1;
    @(negedge clk);
    accValid = 1'b0;
    rNoHit = 0; rProt = 0; rStrobes = 0; rFirst = 0; rDoneCnt = 0; rDoneAt = 0; rEnd = 0;
    for (int k = 1; k < 400; k++) begin
      if (k == 1) begin rNoHit = noHit; rProt = protErr; end
      if (strobe) begin rStrobes++; if (rFirst == 0) rFirst = k; end
      if (done) begin rDoneCnt++; rDoneAt = k; end
      if (!busy) begin rEnd = k; break; end
      if (k == intrudeAt) begin accAddr = intrudeAddr; accValid = 1'b1; end
      if (k == intrudeAt + 1) accValid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic timingCase(input int s, input int l, input int h);
    regWrite(0, 1'b0, 32'h0000_4000);
    regWrite(0, 1'b1, optWord(12, s, l, h, 1'b0, 0, 1'b0, 1'b0, 1'b1));
    runAcc(32'h0000_4abc, 1'b0, 0, 0, 32'h0);
    chkEq($sformatf("R8 strobes s%0d l%0d h%0d", s, l, h), rStrobes, l);
    if (l > 0) chkEq("R8 first strobe cycle", rFirst, s + 1);
    chkEq("R8 done cycle", rDoneAt, s + l + h + 1);
    chkEq("R8 single done", rDoneCnt, 1);
    chkEq("R8 busy length", rEnd, s + l + h + 2);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] base;
    logic [32:0] sz;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state (R1 and outputs)
    chkEq("R8 reset busy", busy, 0);
    chkEq("R8 reset strobe", strobe, 0);
    chkEq("R8 reset done", done, 0);
    chkEq("R11 reset noHit", noHit, 0);
    chkEq("R10 reset protErr", protErr, 0);
    chkEq("R7 reset cardAddr", cardAddr, 0);
    for (int w = 0; w < 8; w++) begin
      regRead(w, 1'b0, rd); chkEq("R1 reset base", rd, 0);
      regRead(w, 1'b1, rd); chkEq("R1 reset opt", rd, 0);
    end

    // R1 write/readback
    for (int w = 0; w < 8; w++) begin
      regWrite(w, 1'b0, 32'h1000_0000 * w + 32'h0000_0a50 + w);
      regWrite(w, 1'b1, 32'hc35a_0000 ^ (32'h0101 * w));
    end
    for (int w = 0; w < 8; w++) begin
      regRead(w, 1'b0, rd); chkEq("R1 base readback", rd, 32'h1000_0000 * w + 32'h0000_0a50 + w);
      regRead(w, 1'b1, rd); chkEq("R1 opt readback", rd, 32'hc35a_0000 ^ (32'h0101 * w));
    end
    clearOpts();

    // R11 miss with everything invalid
    runAcc(32'h0000_0000, 1'b0, 0, 0, 32'h0);
    chkEq("R11 noHit pulse", rNoHit, 1);
    chkEq("R11 no strobe", rStrobes, 0);
    chkEq("R11 no done", rDoneCnt, 0);
    chkEq("R11 not busy", rEnd, 1);

    // R2 valid bit clear never hits
    regWrite(3, 1'b0, 32'h0);
    regWrite(3, 1'b1, optWord(20, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0));
    runAcc(32'h0000_1234, 1'b0, 0, 0, 32'h0);
    chkEq("R2 invalid window misses", rNoHit, 1);
    regWrite(3, 1'b1, optWord(20, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
    runAcc(32'h0000_1234, 1'b0, 0, 0, 32'h0);
    chkEq("R2 valid window hits", rNoHit, 0);
    chkEq("R2 hit index", hitIdx, 3);
    clearOpts();

    // R3 size sweep, all exponents, four edge addresses each
    base = 32'h4000_0000;
    regWrite(0, 1'b0, base);
    for (int n = 0; n <= 26; n++) begin
      sz = 33'd1 << n;
      regWrite(0, 1'b1, optWord(n, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
      runAcc(base - 1, 1'b0, 0, 0, 32'h0);
      chkEq($sformatf("R3 n%0d below base", n), rNoHit, 1);
      runAcc(base, 1'b0, 0, 0, 32'h0);
      chkEq($sformatf("R3 n%0d at base", n), rNoHit, 0);
      runAcc(base + sz[31:0] - 1, 1'b0, 0, 0, 32'h0);
      chkEq($sformatf("R3 n%0d last byte", n), rNoHit, 0);
      chkEq("R7 card address", cardAddr, (base + sz[31:0] - 1) & 32'h03ff_ffff);
      runAcc(base + sz[31:0], 1'b0, 0, 0, 32'h0);
      chkEq($sformatf("R3 n%0d past end", n), rNoHit, 1);
    end

    // R4 out-of-range size codes
    regWrite(0, 1'b0, 32'h0);
    for (int n = 27; n <= 31; n++) begin
      regWrite(0, 1'b1, optWord(n, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
      runAcc(32'h0000_0000, 1'b0, 0, 0, 32'h0);
      chkEq($sformatf("R4 code for n%0d never hits", n), rNoHit, 1);
    end
    clearOpts();

    // R5 space sweep against an attribute window
    regWrite(1, 1'b0, 32'h0010_0000);
    regWrite(1, 1'b1, optWord(16, 0, 0, 0, 1'b0, 2, 1'b0, 1'b0, 1'b1));
    for (int sp = 0; sp < 8; sp++) begin
      runAcc(32'h0010_0040, 1'b0, sp, 0, 32'h0);
      chkEq($sformatf("R5 space %0d", sp), rNoHit, (sp == 2) ? 0 : 1);
    end
    clearOpts();

    // R6 each window alone, then overlapping priority
    for (int w = 0; w < 8; w++) begin
      regWrite(w, 1'b0, 32'h0100_0000 * w);
      regWrite(w, 1'b1, optWord(10, 0, 0, 0, 1'b0, 3, 1'b0, 1'b0, 1'b1));
    end
    for (int w = 0; w < 8; w++) begin
      runAcc(32'h0100_0000 * w + 32'h10, 1'b0, 3, 0, 32'h0);
      chkEq($sformatf("R6 lone window %0d", w), hitIdx, w);
    end
    clearOpts();
    regWrite(2, 1'b0, 32'h2000_0000);
    regWrite(5, 1'b0, 32'h2000_0000);
    regWrite(7, 1'b0, 32'h2000_0000);
    regWrite(7, 1'b1, optWord(12, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
    regWrite(5, 1'b1, optWord(12, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
    regWrite(2, 1'b1, optWord(12, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
    runAcc(32'h2000_0100, 1'b0, 0, 0, 32'h0);
    chkEq("R6 lowest of 2,5,7", hitIdx, 2);
    regWrite(2, 1'b1, 32'h0);
    runAcc(32'h2000_0100, 1'b0, 0, 0, 32'h0);
    chkEq("R6 lowest of 5,7", hitIdx, 5);
    regWrite(5, 1'b1, 32'h0);
    runAcc(32'h2000_0100, 1'b0, 0, 0, 32'h0);
    chkEq("R6 only 7", hitIdx, 7);
    clearOpts();

    // R7 latched context
    regWrite(4, 1'b0, 32'hfc00_0000);
    regWrite(4, 1'b1, optWord(26, 0, 1, 0, 1'b1, 6, 1'b1, 1'b0, 1'b1));
    runAcc(32'hfdab_cdef, 1'b1, 6, 0, 32'h0);
    chkEq("R7 cardAddr low bits", cardAddr, 26'h1ab_cdef);
    chkEq("R7 cardSpace", cardSpace, 6);
    chkEq("R7 slotB", slotB, 1);
    chkEq("R7 port16", port16, 1);
    chkEq("R7 cardWrite", cardWrite, 1);
    chkEq("R7 hitIdx", hitIdx, 4);
    regWrite(4, 1'b1, optWord(26, 0, 1, 0, 1'b0, 4, 1'b0, 1'b0, 1'b1));
    runAcc(32'hfc00_0001, 1'b0, 4, 0, 32'h0);
    chkEq("R7 slotB cleared", slotB, 0);
    chkEq("R7 port16 cleared", port16, 0);
    chkEq("R7 cardSpace dma", cardSpace, 4);
    chkEq("R7 cardWrite read", cardWrite, 0);
    clearOpts();

    // R10 write protect
    regWrite(6, 1'b0, 32'h0000_8000);
    regWrite(6, 1'b1, optWord(12, 2, 3, 1, 1'b0, 0, 1'b0, 1'b1, 1'b1));
    runAcc(32'h0000_8010, 1'b1, 0, 0, 32'h0);
    chkEq("R10 protErr pulse", rProt, 1);
    chkEq("R10 no noHit", rNoHit, 0);
    chkEq("R10 no strobe", rStrobes, 0);
    chkEq("R10 no done", rDoneCnt, 0);
    chkEq("R10 not busy", rEnd, 1);
    runAcc(32'h0000_8010, 1'b0, 0, 0, 32'h0);
    chkEq("R10 read allowed", rProt, 0);
    chkEq("R10 read strobes", rStrobes, 3);
    chkEq("R10 read hit idx", hitIdx, 6);
    clearOpts();

    // R8 strobe timing profiles
    timingCase(4, 8, 2);
    timingCase(6, 24, 8);
    timingCase(0, 0, 0);
    timingCase(0, 1, 0);
    timingCase(15, 31, 15);
    timingCase(1, 0, 1);
    timingCase(3, 0, 0);
    clearOpts();

    // R9 request ignored while busy
    regWrite(0, 1'b0, 32'h0000_0000);
    regWrite(0, 1'b1, optWord(12, 6, 24, 8, 1'b0, 0, 1'b0, 1'b0, 1'b1));
    regWrite(1, 1'b0, 32'h0100_0000);
    regWrite(1, 1'b1, optWord(12, 0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b1));
    runAcc(32'h0000_0123, 1'b0, 0, 3, 32'h0100_0010);
    chkEq("R9 single done", rDoneCnt, 1);
    chkEq("R9 length unchanged", rEnd, 6 + 24 + 8 + 2);
    chkEq("R9 hitIdx kept", hitIdx, 0);
    chkEq("R9 cardAddr kept", cardAddr, 26'h123);
    @(negedge clk);
    chkEq("R9 stays idle", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule